// File: doc/BRIEF.md
# ADC Result Byte-Access Register

This block keeps the most recent completed analog-to-digital conversion result, 10 bits wide, and lets an 8-bit bus read it as two bytes: a low byte and a high byte. A single alignment input decides how the 10 bits sit inside the 16-bit byte pair. With right alignment the value fills the low byte and spills its top two bits into the bottom of the high byte. With left alignment the top eight bits fill the high byte and the two remaining bits occupy the top of the low byte.

A two-byte read must return halves of the same conversion. Reading the low byte therefore freezes the visible result until the high byte is read. A conversion that finishes in that window goes to a single pending slot, and the slot is committed when the high byte is read. A reader that needs only eight bits can use left alignment and read the high byte on its own. Such a read never leaves the register frozen. Signed differential results pass through as raw 10-bit two's complement, with no sign extension into the padding bits.

Top module: `adc_result_port`

## Requirements
- R1: After synchronous reset, both bytes read as 0x00 and the register is unlocked, so the next completed conversion is committed.
- R2: With `left_align_i` = 0, the low byte (address 0) carries result bits 7:0. The high byte (address 1) carries result bits 9:8 in its bits 1:0, and its bits 7:2 are zero.
- R3: With `left_align_i` = 1, the high byte carries result bits 9:2. The low byte carries result bits 1:0 in its bits 7:6, and its bits 5:0 are zero.
- R4: When `rd_en_i` is high at a clock edge, `rd_data_o` takes, at that edge, the byte selected by `rd_addr_i` (0 = low, 1 = high), computed from the result stored before that edge. Without a read, `rd_data_o` keeps its value.
- R5: While the register is unlocked, a `conv_done_i` strobe stores `conv_result_i` at that edge, and the next read returns it.
- R6: A low-byte read locks the register. Conversions that complete in the cycle of that read, or later, do not change the readable result until a high-byte read. Further low-byte reads keep the lock.
- R7: A high-byte read with no low-byte read before it leaves the register unlocked, so later conversions are committed at once.
- R8: Conversions that complete while the register is locked go to one pending slot, where the newest overwrites any older one. The slot is committed at the edge of the unlocking high-byte read.
- R9: When a conversion strobe coincides with the unlocking high-byte read, the read returns the old high byte. The coinciding result, and not an older pending one, is then committed.
- R10: Changing `left_align_i` changes only the byte mapping. Both alignments read back the same stored 10-bit value.
- R11: A two's complement result is stored unchanged. For example, 0x380 reads as low 0x80 and high 0x03 with right alignment, and the padding bits carry no sign copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 1 | One-cycle strobe: a conversion has completed |
| conv_result_i | input | 10 | Result carried by the strobe |
| left_align_i | input | 1 | 1 = left-aligned byte images, 0 = right-aligned |
| rd_en_i | input | 1 | Byte read strobe |
| rd_addr_i | input | 1 | Byte select: 0 = low byte, 1 = high byte |
| rd_data_o | output | 8 | Registered read data |

## Verification
Assertions check on every cycle that the lock follows the read sequence, and that the stored result stays frozen while it is held. They also check that a commit takes either the coinciding strobe or the pending slot, in that priority. In addition they cover the zero padding bits of each alignment and the holding of `rd_data_o` between reads. Some properties only show across a whole read sequence, and only the bench scenarios reach them: a two-byte read returns halves of a single conversion, the newest pending result wins, a lone high-byte read leaves no lock behind, and a change of alignment leaves the stored value as it was.

// File: rtl/adc_rp_pkg.sv
package adc_rp_pkg;

    localparam int RES_W_DEF = 10;
    localparam int BUS_W_DEF = 8;

    typedef enum logic {
        SEL_LO = 1'b0,
        SEL_HI = 1'b1
    } byte_sel_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic lo_rd;
        logic hi_rd;
    } rd_decode_t;

    function automatic rd_decode_t decode_read(input logic en, input logic addr);
        rd_decode_t d;
        d.lo_rd = en && (byte_sel_e'(addr) == SEL_LO);
        d.hi_rd = en && (byte_sel_e'(addr) == SEL_HI);
        return d;
    endfunction

endpackage

// File: rtl/adc_rp_lock_ctrl.sv
module adc_rp_lock_ctrl
    import adc_rp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  rd_decode_t rd_dec,
    output logic       hold_o,
    output logic       locked_o
);

    lock_state_e state_q;
    lock_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (rd_dec.hi_rd) begin
            state_d = LK_OPEN;
        end else if (rd_dec.lo_rd) begin
            state_d = LK_HELD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // Freeze applies from the cycle of the low read until the high read.
    assign hold_o   = ((state_q == LK_HELD) && !rd_dec.hi_rd) || rd_dec.lo_rd;
    assign locked_o = (state_q == LK_HELD);

    assert_lo_locks_R6: assert property (@(posedge clk) disable iff (rst)
        rd_dec.lo_rd |=> locked_o);

    assert_hi_unlocks_R7: assert property (@(posedge clk) disable iff (rst)
        rd_dec.hi_rd |=> !locked_o);

endmodule

// File: rtl/adc_rp_store.sv
module adc_rp_store #(
    parameter int RES_W = adc_rp_pkg::RES_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_value,
    input  logic             hold,
    output logic [RES_W-1:0] result_o
);

    logic [RES_W-1:0] result_q;
    logic [RES_W-1:0] pend_q;
    logic             pend_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            pend_q   <= '0;
            pend_v_q <= 1'b0;
        end else if (hold) begin
            if (conv_done) begin
                pend_q   <= conv_value;
                pend_v_q <= 1'b1;
            end
        end else begin
            if (conv_done) begin
                result_q <= conv_value;
                pend_v_q <= 1'b0;
            end else if (pend_v_q) begin
                result_q <= pend_q;
                pend_v_q <= 1'b0;
            end
        end
    end

    assign result_o = result_q;

    assert_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        hold |=> (result_o == $past(result_o)));

    assert_newest_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (!hold && conv_done) |=> (result_o == $past(conv_value)));

    assert_pend_commit_R8: assert property (@(posedge clk) disable iff (rst)
        (!hold && !conv_done && pend_v_q) |=> (result_o == $past(pend_q)));

    assert_idle_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (!conv_done && !pend_v_q) |=> $stable(result_o));

endmodule

// File: rtl/adc_rp_byte_mux.sv
module adc_rp_byte_mux #(
    parameter int RES_W = adc_rp_pkg::RES_W_DEF,
    parameter int BUS_W = adc_rp_pkg::BUS_W_DEF
) (
    input  logic [RES_W-1:0] result,
    input  logic             left_align,
    output logic [BUS_W-1:0] lo_o,
    output logic [BUS_W-1:0] hi_o
);

    localparam int PAIR_W = 2 * BUS_W;
    localparam int PAD_W  = PAIR_W - RES_W;

    logic [PAIR_W-1:0] right_pair;
    logic [PAIR_W-1:0] left_pair;
    logic [PAIR_W-1:0] pair;

    generate
        if (PAD_W == 0) begin : g_full
            assign right_pair = result;
            assign left_pair  = result;
        end else begin : g_padded
            assign right_pair = {{PAD_W{1'b0}}, result};
            assign left_pair  = {result, {PAD_W{1'b0}}};
        end
    endgenerate

    assign pair = left_align ? left_pair : right_pair;
    assign lo_o = pair[BUS_W-1:0];
    assign hi_o = pair[PAIR_W-1:BUS_W];

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
    import adc_rp_pkg::*;
#(
    parameter int RES_W = adc_rp_pkg::RES_W_DEF,
    parameter int BUS_W = adc_rp_pkg::BUS_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done_i,
    input  logic [RES_W-1:0] conv_result_i,
    input  logic             left_align_i,
    input  logic             rd_en_i,
    input  logic             rd_addr_i,
    output logic [BUS_W-1:0] rd_data_o
);

    localparam int PAD_W   = 2 * BUS_W - RES_W;
    localparam int HI_USED = RES_W - BUS_W;

    rd_decode_t       rd_dec;
    logic             hold;
    logic             locked;
    logic [RES_W-1:0] stored;
    logic [BUS_W-1:0] lo_img;
    logic [BUS_W-1:0] hi_img;
    logic [BUS_W-1:0] rd_data_q;

    assign rd_dec = decode_read(rd_en_i, rd_addr_i);

    adc_rp_lock_ctrl u_lock (
        .clk      (clk),
        .rst      (rst),
        .rd_dec   (rd_dec),
        .hold_o   (hold),
        .locked_o (locked)
    );

    adc_rp_store #(.RES_W(RES_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .conv_done  (conv_done_i),
        .conv_value (conv_result_i),
        .hold       (hold),
        .result_o   (stored)
    );

    adc_rp_byte_mux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_mux (
        .result     (stored),
        .left_align (left_align_i),
        .lo_o       (lo_img),
        .hi_o       (hi_img)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data_q <= '0;
        end else if (rd_en_i) begin
            rd_data_q <= rd_dec.hi_rd ? hi_img : lo_img;
        end
    end

    assign rd_data_o = rd_data_q;

    assert_rd_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> $stable(rd_data_o));

    assert_hi_pad_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_dec.hi_rd && !left_align_i) |=> (rd_data_o[BUS_W-1:HI_USED] == '0));

    assert_lo_pad_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_dec.lo_rd && left_align_i) |=> (rd_data_o[PAD_W-1:0] == '0));

    assert_one_lock_R6: assert property (@(posedge clk) disable iff (rst)
        (locked && !rd_dec.hi_rd) |=> locked);

endmodule

// File: tb/adc_result_port_tb.sv
`timescale 1ns/1ps
module adc_result_port_tb_top;

    localparam int NV = 12;
    // {value[9:0], left_align, expected low, expected high}
    localparam logic [26:0] VEC [NV] = '{
        {10'h2A5, 1'b0, 8'hA5, 8'h02},
        {10'h2A5, 1'b1, 8'h40, 8'hA9},
        {10'h3FF, 1'b0, 8'hFF, 8'h03},
        {10'h3FF, 1'b1, 8'hC0, 8'hFF},
        {10'h001, 1'b0, 8'h01, 8'h00},
        {10'h001, 1'b1, 8'h40, 8'h00},
        {10'h200, 1'b0, 8'h00, 8'h02},
        {10'h200, 1'b1, 8'h00, 8'h80},
        {10'h155, 1'b0, 8'h55, 8'h01},
        {10'h155, 1'b1, 8'h40, 8'h55},
        {10'h0C3, 1'b0, 8'hC3, 8'h00},
        {10'h0C3, 1'b1, 8'hC0, 8'h30}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_done = 1'b0;
    logic [9:0] conv_val = '0;
    logic       left_align = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] d;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    adc_result_port dut_i (
        .clk           (clk),
        .rst           (rst),
        .conv_done_i   (conv_done),
        .conv_result_i (conv_val),
        .left_align_i  (left_align),
        .rd_en_i       (rd_en),
        .rd_addr_i     (rd_addr),
        .rd_data_o     (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic conv(input logic [9:0] v);
        @(negedge clk);
        conv_done = 1'b1;
        conv_val  = v;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    // Read one byte, optionally with a coinciding conversion strobe.
    task automatic rd_byte(input logic addr, input logic with_conv,
                           input logic [9:0] v, output logic [7:0] data);
        @(negedge clk);
        rd_en     = 1'b1;
        rd_addr   = addr;
        conv_done = with_conv;
        conv_val  = v;
        @(negedge clk);
        rd_en     = 1'b0;
        conv_done = 1'b0;
        data      = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values, and no lock left after reset
        check("R1 reset rd_data", rd_data, 8'h00);
        rd_byte(1'b1, 1'b0, '0, d); check("R1 reset high byte", d, 8'h00);
        rd_byte(1'b0, 1'b0, '0, d); check("R1 reset low byte", d, 8'h00);
        rd_byte(1'b1, 1'b0, '0, d);

        // Vector walk, R2/R3 mapping, R5 commit, R11 signed values
        for (int i = 0; i < NV; i++) begin
            left_align = VEC[i][16];
            conv(VEC[i][26:17]);
            rd_byte(1'b0, 1'b0, '0, d);
            check(VEC[i][16] ? "R3 R5 R11 low byte" : "R2 R5 R11 low byte", d, VEC[i][15:8]);
            rd_byte(1'b1, 1'b0, '0, d);
            check(VEC[i][16] ? "R3 R5 R11 high byte" : "R2 R5 R11 high byte", d, VEC[i][7:0]);
        end

        // R11: negative value without sign extension
        left_align = 1'b0;
        conv(10'h380);
        rd_byte(1'b0, 1'b0, '0, d); check("R11 neg low", d, 8'h80);
        rd_byte(1'b1, 1'b0, '0, d); check("R11 neg high", d, 8'h03);

        // R6/R8: lock, newest pending wins, commit on high read
        conv(10'h111);
        rd_byte(1'b0, 1'b0, '0, d); check("R6 low before lock", d, 8'h11);
        conv(10'h222);
        conv(10'h333);
        rd_byte(1'b0, 1'b0, '0, d); check("R6 low while locked", d, 8'h11);
        rd_byte(1'b1, 1'b0, '0, d); check("R6 high of same conversion", d, 8'h01);
        rd_byte(1'b0, 1'b0, '0, d); check("R8 newest pending low", d, 8'h33);
        rd_byte(1'b1, 1'b0, '0, d); check("R8 newest pending high", d, 8'h03);

        // R6: conversion in the same cycle as the low read is held back
        rd_byte(1'b0, 1'b1, 10'h044, d); check("R6 same-cycle low", d, 8'h33);
        rd_byte(1'b1, 1'b0, '0, d); check("R6 same-cycle high old", d, 8'h03);
        rd_byte(1'b0, 1'b0, '0, d); check("R6 held result committed", d, 8'h44);
        rd_byte(1'b1, 1'b0, '0, d); check("R6 held result high", d, 8'h00);

        // R9: strobe together with unlocking high read beats older pending
        rd_byte(1'b0, 1'b0, '0, d); check("R9 low", d, 8'h44);
        conv(10'h1AB);
        rd_byte(1'b1, 1'b1, 10'h2CD, d); check("R9 high returns old", d, 8'h00);
        rd_byte(1'b0, 1'b0, '0, d); check("R9 coinciding committed low", d, 8'hCD);
        rd_byte(1'b1, 1'b0, '0, d); check("R9 coinciding committed high", d, 8'h02);

        // R7: high-only reads in left mode never lock
        left_align = 1'b1;
        rd_byte(1'b1, 1'b0, '0, d); check("R7 high only", d, 8'hB3);
        conv(10'h0F0);
        rd_byte(1'b1, 1'b0, '0, d); check("R7 new value after high-only", d, 8'h3C);

        // R10: alignment change keeps the stored value
        left_align = 1'b0;
        rd_byte(1'b0, 1'b0, '0, d); check("R10 right low", d, 8'hF0);
        rd_byte(1'b1, 1'b0, '0, d); check("R10 right high", d, 8'h00);
        left_align = 1'b1;
        rd_byte(1'b1, 1'b0, '0, d); check("R10 left high", d, 8'h3C);
        rd_byte(1'b0, 1'b0, '0, d); check("R10 left low", d, 8'h00);
        rd_byte(1'b1, 1'b0, '0, d);

        // R4: output holds with no read, even across a conversion
        conv(10'h3C7);
        repeat (3) @(negedge clk);
        check("R4 hold without read", rd_data, 8'h3C);
        rd_byte(1'b1, 1'b0, '0, d); check("R4 read updates", d, 8'hF1);

        // R1: reset in mid-lock clears result and lock
        rd_byte(1'b0, 1'b0, '0, d);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 rd_data after reset", rd_data, 8'h00);
        conv(10'h0AA);
        left_align = 1'b0;
        rd_byte(1'b0, 1'b0, '0, d); check("R1 unlocked after reset", d, 8'hAA);
        rd_byte(1'b1, 1'b0, '0, d);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule